// File: doc/BRIEF.md
# Predicated Vector Reduction Unit

This block folds a short vector of fixed-width integer elements into one scalar under a per-element predicate mask. A request carries the element vector, the mask, an active length, an operation code (wrapping add, minimum, maximum, and, or, xor) and a signed/unsigned choice for comparisons. With the reduce mode bit set, the unit walks the elements one per cycle in rising index order and skips every element that is masked off or lies beyond the active length. Each partial result is written back into an internal element buffer at the slot of the lowest active element. That slot therefore holds the final scalar, and its index is reported with the value.

With the reduce mode bit clear, the request is a plain element-wise pass: the input vector is copied unchanged into the buffer. Two operation codes name single-source operations. A reduction request that carries one of them is refused with an error flag and changes nothing. A reduction with no active element finishes with an empty flag and leaves the loaded input vector untouched.

Top module: `pred_reduce`

## Requirements
- R1: After reset, busy, done, errOp and empty are 0, result and resultIdx are 0, and every slot of vecOut is 0.
- R2: With reduceMode=1 and opSel=0 (add), result is the sum of the active elements modulo 2^64, folded in increasing index order.
- R3: opSel=1 (min) and opSel=2 (max) compare as two's-complement numbers when isSigned=1 and as unsigned numbers when isSigned=0.
- R4: opSel=3, 4 and 5 give the bitwise and, or and xor of the active elements.
- R5: An element is active only when its predMask bit is 1 and its index is below the active length. A vl above the element count is treated as the element count. Inactive elements do not affect the result.
- R6: On completion, resultIdx is the lowest active index. vecOut (slot i at bits i*64 and up) holds result in that slot and the loaded input elements in all other slots.
- R7: When no element is active, done comes with empty=1, result=0, and vecOut equal to the loaded input vector.
- R8: A reduction request with opSel=6 or opSel=7 (single-source codes) raises done with errOp=1 in the cycle after the start edge, leaves vecOut unchanged, and gives result=0.
- R9: With reduceMode=0, vecOut becomes vecIn and done rises in the cycle after the start edge, with errOp=0, empty=0 and result=0.
- R10: done is a one-cycle pulse. For an accepted reduction it appears max(L,1) edges after the start edge, where L is the clamped active length. busy is high from the start edge until done.
- R11: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when busy is low |
| reduceMode | input | 1 | 1 = reduce, 0 = element-wise pass |
| opSel | input | 3 | Operation code |
| isSigned | input | 1 | Signed comparison for min/max |
| vl | input | 4 | Active vector length |
| predMask | input | 8 | Per-element predicate |
| vecIn | input | 512 | Input elements, slot i at bits [i*64 +: 64] |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | Completion pulse |
| errOp | output | 1 | Single-source operation refused in reduce mode |
| empty | output | 1 | No active element |
| result | output | 64 | Scalar result |
| resultIdx | output | 3 | Slot that holds the result |
| vecOut | output | 512 | Internal element buffer |

## Verification
The capture of the first active element and the completion of the walk can fall on the same edge. When the only active element is the last one inside the active length, its value is taken as the accumulator seed, written to its own slot, and the done pulse is raised, all at one edge. The table provokes this with a single mask bit at index 7 and full length, and also with the same mask and a length of 7, which must instead report empty. Both cases are judged on the result, the index, the latency and the buffer contents together.

// File: rtl/pred_reduce_pkg.sv
package pred_reduce_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_MIN = 3'd1,
    OP_MAX = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_NEG = 3'd6,
    OP_NOT = 3'd7
  } red_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAcc;   // new request: clear accumulator, latch op
    logic loadBuf;  // copy vecIn into the element buffer
    logic accum;    // fold the element at the current index
    logic first;    // current element seeds the accumulator
  } red_strb_t;

endpackage

// File: rtl/pred_reduce_alu.sv
module pred_reduce_alu
  import pred_reduce_pkg::*;
#(
  parameter int ELEM_W = 64
) (
  input  logic [ELEM_W-1:0] accIn,
  input  logic [ELEM_W-1:0] elemIn,
  input  logic [2:0]        opCode,
  input  logic              sgnCmp,
  output logic [ELEM_W-1:0] aluOut
);

  logic elemLess;

  always_comb begin
    if (sgnCmp) elemLess = $signed(elemIn) < $signed(accIn);
    else        elemLess = elemIn < accIn;
  end

  always_comb begin
    case (opCode)
      OP_ADD:  aluOut = accIn + elemIn;
      OP_MIN:  aluOut = elemLess ? elemIn : accIn;
      OP_MAX:  aluOut = elemLess ? accIn : elemIn;
      OP_AND:  aluOut = accIn & elemIn;
      OP_OR:   aluOut = accIn | elemIn;
      OP_XOR:  aluOut = accIn ^ elemIn;
      default: aluOut = accIn;
    endcase
  end

endmodule

// File: rtl/pred_reduce_ctrl.sv
module pred_reduce_ctrl
  import pred_reduce_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int IDX_W    = 3,
  parameter int VL_W     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                reduceMode,
  input  logic [2:0]          opSel,
  input  logic [VL_W-1:0]     vl,
  input  logic [NUM_ELEM-1:0] predMask,
  output red_strb_t           strb,
  output logic [IDX_W-1:0]    curIdx,
  output logic                busy,
  output logic                done,
  output logic                errOp,
  output logic                empty
);

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e              state;
  logic [VL_W-1:0]     vlQ;
  logic [NUM_ELEM-1:0] predQ;
  logic                haveAcc;
  logic                accept;
  logic                badOp;
  logic                active;
  logic                lastStep;
  logic [VL_W-1:0]     vlClamp;

  assign accept   = start && (state == S_IDLE);
  assign badOp    = (opSel == OP_NEG) || (opSel == OP_NOT);
  assign vlClamp  = (vl > VL_W'(NUM_ELEM)) ? VL_W'(NUM_ELEM) : vl;
  assign active   = (VL_W'(curIdx) < vlQ) && predQ[curIdx];
  assign lastStep = (VL_W'(curIdx) + VL_W'(1)) >= vlQ;
  assign busy     = (state == S_RUN);

  always_comb begin
    strb = '0;
    if (accept) begin
      strb.clrAcc  = 1'b1;
      strb.loadBuf = !(reduceMode && badOp);
    end
    if (state == S_RUN && active) begin
      strb.accum = 1'b1;
      strb.first = !haveAcc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curIdx  <= '0;
      vlQ     <= '0;
      predQ   <= '0;
      haveAcc <= 1'b0;
      done    <= 1'b0;
      errOp   <= 1'b0;
      empty   <= 1'b0;
    end else begin
      done  <= 1'b0;
      errOp <= 1'b0;
      empty <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (!reduceMode) begin
              done <= 1'b1;
            end else if (badOp) begin
              done  <= 1'b1;
              errOp <= 1'b1;
            end else begin
              state   <= S_RUN;
              curIdx  <= '0;
              haveAcc <= 1'b0;
              vlQ     <= vlClamp;
              predQ   <= predMask;
            end
          end
        end
        S_RUN: begin
          if (active) haveAcc <= 1'b1;
          if (lastStep) begin
            state <= S_IDLE;
            done  <= 1'b1;
            empty <= !(haveAcc || active);
          end else begin
            curIdx <= curIdx + IDX_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pred_reduce_dp.sv
module pred_reduce_dp
  import pred_reduce_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  red_strb_t                  strb,
  input  logic [IDX_W-1:0]           curIdx,
  input  logic [2:0]                 opSel,
  input  logic                       isSigned,
  input  logic [NUM_ELEM*ELEM_W-1:0] vecIn,
  output logic [ELEM_W-1:0]          result,
  output logic [IDX_W-1:0]           resultIdx,
  output logic [NUM_ELEM*ELEM_W-1:0] vecOut
);

  logic [ELEM_W-1:0] elemBuf [NUM_ELEM];
  logic [2:0]        opQ;
  logic              sgnQ;
  logic [ELEM_W-1:0] curElem;
  logic [ELEM_W-1:0] aluOut;
  logic [ELEM_W-1:0] newAcc;
  logic [IDX_W-1:0]  wrIdx;

  assign curElem = elemBuf[curIdx];
  assign newAcc  = strb.first ? curElem : aluOut;
  assign wrIdx   = strb.first ? curIdx : resultIdx;

  pred_reduce_alu #(.ELEM_W(ELEM_W)) u_alu (
    .accIn  (result),
    .elemIn (curElem),
    .opCode (opQ),
    .sgnCmp (sgnQ),
    .aluOut (aluOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      resultIdx <= '0;
      opQ       <= '0;
      sgnQ      <= 1'b0;
      for (int i = 0; i < NUM_ELEM; i++) elemBuf[i] <= '0;
    end else begin
      if (strb.clrAcc) begin
        result    <= '0;
        resultIdx <= '0;
        opQ       <= opSel;
        sgnQ      <= isSigned;
      end
      if (strb.loadBuf) begin
        for (int i = 0; i < NUM_ELEM; i++) elemBuf[i] <= vecIn[i*ELEM_W +: ELEM_W];
      end
      if (strb.accum) begin
        result         <= newAcc;
        elemBuf[wrIdx] <= newAcc;
        if (strb.first) resultIdx <= curIdx;
      end
    end
  end

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_pack
    assign vecOut[g*ELEM_W +: ELEM_W] = elemBuf[g];
  end

endmodule

// File: rtl/pred_reduce.sv
module pred_reduce
  import pred_reduce_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int VL_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       reduceMode,
  input  logic [2:0]                 opSel,
  input  logic                       isSigned,
  input  logic [VL_W-1:0]            vl,
  input  logic [NUM_ELEM-1:0]        predMask,
  input  logic [NUM_ELEM*ELEM_W-1:0] vecIn,
  output logic                       busy,
  output logic                       done,
  output logic                       errOp,
  output logic                       empty,
  output logic [ELEM_W-1:0]          result,
  output logic [IDX_W-1:0]           resultIdx,
  output logic [NUM_ELEM*ELEM_W-1:0] vecOut
);

  red_strb_t        strb;
  logic [IDX_W-1:0] curIdx;

  pred_reduce_ctrl #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .VL_W(VL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .reduceMode (reduceMode),
    .opSel      (opSel),
    .vl         (vl),
    .predMask   (predMask),
    .strb       (strb),
    .curIdx     (curIdx),
    .busy       (busy),
    .done       (done),
    .errOp      (errOp),
    .empty      (empty)
  );

  pred_reduce_dp #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .curIdx    (curIdx),
    .opSel     (opSel),
    .isSigned  (isSigned),
    .vecIn     (vecIn),
    .result    (result),
    .resultIdx (resultIdx),
    .vecOut    (vecOut)
  );

endmodule

// File: rtl/pred_reduce_chk.sv
module pred_reduce_chk #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  parameter int VL_W     = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       reduceMode,
  input logic [2:0]                 opSel,
  input logic [NUM_ELEM*ELEM_W-1:0] vecIn,
  input logic                       busy,
  input logic                       done,
  input logic                       errOp,
  input logic                       empty,
  input logic [ELEM_W-1:0]          result,
  input logic [NUM_ELEM*ELEM_W-1:0] vecOut
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  p_empty_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (done && !errOp && result == '0));

  p_err_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && reduceMode && (opSel == 3'd6 || opSel == 3'd7))
      |=> (done && errOp && result == '0 && $stable(vecOut)));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !reduceMode)
      |=> (done && !errOp && !empty && vecOut == $past(vecIn)));

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !errOp);

endmodule

bind pred_reduce pred_reduce_chk #(
  .NUM_ELEM (NUM_ELEM),
  .ELEM_W   (ELEM_W),
  .VL_W     (VL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .reduceMode (reduceMode),
  .opSel      (opSel),
  .vecIn      (vecIn),
  .busy       (busy),
  .done       (done),
  .errOp      (errOp),
  .empty      (empty),
  .result     (result),
  .vecOut     (vecOut)
);

// File: tb/pred_reduce_bench.sv
`timescale 1ns/1ps
module pred_reduce_bench;

  localparam int N = 8;
  localparam int W = 64;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           reduceMode = 1'b0;
  logic [2:0]     opSel = '0;
  logic           isSigned = 1'b0;
  logic [3:0]     vl = '0;
  logic [N-1:0]   predMask = '0;
  logic [N*W-1:0] vecIn = '0;
  logic           busy, done, errOp, empty;
  logic [W-1:0]   result;
  logic [2:0]     resultIdx;
  logic [N*W-1:0] vecOut;

  int applied = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pred_reduce u_pred_reduce (
    .clk(clk), .rstN(rstN), .start(start), .reduceMode(reduceMode),
    .opSel(opSel), .isSigned(isSigned), .vl(vl), .predMask(predMask),
    .vecIn(vecIn), .busy(busy), .done(done), .errOp(errOp), .empty(empty),
    .result(result), .resultIdx(resultIdx), .vecOut(vecOut)
  );

  // stimulus/expectation record
  typedef struct packed {
    logic [2:0]  op;
    logic        sgn;
    logic [7:0]  pred;
    logic [3:0]  len;
    logic [63:0] expRes;
    logic [2:0]  expIdx;
    logic        expEmpty;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 8'hFF, 4'd8,  64'h0000_0000_0000_0111, 3'd0, 1'b0}, // R2 add
    '{3'd0, 1'b0, 8'h06, 4'd8,  64'h0000_0000_0000_000D, 3'd1, 1'b0}, // R5 + R2 wrap
    '{3'd1, 1'b1, 8'hFF, 4'd8,  64'h8000_0000_0000_0000, 3'd0, 1'b0}, // R3 min signed
    '{3'd1, 1'b0, 8'hFF, 4'd8,  64'h0000_0000_0000_0001, 3'd0, 1'b0}, // R3 min unsigned
    '{3'd2, 1'b1, 8'hFF, 4'd8,  64'h7FFF_FFFF_FFFF_FFFF, 3'd0, 1'b0}, // R3 max signed
    '{3'd2, 1'b0, 8'hFF, 4'd8,  64'hFFFF_FFFF_FFFF_FFFD, 3'd0, 1'b0}, // R3 max unsigned
    '{3'd2, 1'b1, 8'h0A, 4'd8,  64'hFFFF_FFFF_FFFF_FFFD, 3'd1, 1'b0}, // R5 max signed
    '{3'd3, 1'b0, 8'h30, 4'd8,  64'h0000_0000_0000_0000, 3'd4, 1'b0}, // R4 and
    '{3'd4, 1'b0, 8'h31, 4'd8,  64'h0000_0000_0000_00FF, 3'd0, 1'b0}, // R4 or
    '{3'd5, 1'b0, 8'h05, 4'd8,  64'h0000_0000_0000_0015, 3'd0, 1'b0}, // R4 xor
    '{3'd0, 1'b0, 8'hFF, 4'd3,  64'h0000_0000_0000_0012, 3'd0, 1'b0}, // R5 length cut
    '{3'd0, 1'b0, 8'hFF, 4'd12, 64'h0000_0000_0000_0111, 3'd0, 1'b0}, // R5 clamp
    '{3'd0, 1'b0, 8'h80, 4'd8,  64'h0000_0000_0000_0001, 3'd7, 1'b0}, // R6 seed+done
    '{3'd0, 1'b0, 8'h80, 4'd7,  64'h0,                   3'd0, 1'b1}, // R7 beyond length
    '{3'd0, 1'b0, 8'h00, 4'd8,  64'h0,                   3'd0, 1'b1}, // R7 no mask
    '{3'd0, 1'b0, 8'hFF, 4'd0,  64'h0,                   3'd0, 1'b1}  // R7 zero length
  };

  function automatic logic [W-1:0] elemA(input int i);
    case (i)
      0: return 64'h0000_0000_0000_0005;
      1: return 64'hFFFF_FFFF_FFFF_FFFD;
      2: return 64'h0000_0000_0000_0010;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0000_0000_00F0;
      5: return 64'h0000_0000_0000_000F;
      6: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_0000_0001;
    endcase
  endfunction

  function automatic logic [N*W-1:0] packA();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = elemA(i);
    return v;
  endfunction

  function automatic logic [N*W-1:0] packB();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = 64'h1111_1111_1111_1111 * (i + 1);
    return v;
  endfunction

  function automatic string opTag(input logic [2:0] op);
    if (op == 3'd0) return "R2";
    if (op == 3'd1 || op == 3'd2) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkVec(input string tag, input logic [N*W-1:0] exp);
    int bad = 0;
    for (int i = 0; i < N; i++) if (vecOut[i*W +: W] !== exp[i*W +: W]) bad++;
    chk(bad == 0, tag, W'(bad), '0);
  endtask

  // Drive one request and count edges from the start edge to done
  task automatic run(input logic m, input logic [2:0] op, input logic sgn,
                     input logic [7:0] pr, input logic [3:0] len,
                     input logic [N*W-1:0] v, output int cnt);
    reduceMode = m; opSel = op; isSigned = sgn; predMask = pr; vl = len; vecIn = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    int cnt;
    logic [N*W-1:0] expV;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !errOp && !empty, "R1 flags", {60'b0, busy, done, errOp, empty}, '0);
    chk(result == '0 && resultIdx == '0, "R1 result", result, '0);
    chkVec("R1 buffer", '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      int expLat;
      vec_t t = TBL[k];
      string tg = (t.pred != 8'hFF || t.len != 4'd8) ? "R5" : opTag(t.op);
      expLat = (t.len == 0) ? 1 : ((t.len > 8) ? 8 : int'(t.len));
      run(1'b1, t.op, t.sgn, t.pred, t.len, packA(), cnt);
      chk(result === t.expRes, tg, result, t.expRes);
      chk(resultIdx === t.expIdx, "R6 index", W'(resultIdx), W'(t.expIdx));
      chk(empty === t.expEmpty && !errOp, "R7 empty flag", W'(empty), W'(t.expEmpty));
      chk(cnt == expLat, "R10 latency", W'(cnt), W'(expLat));
      expV = packA();
      if (!t.expEmpty) expV[t.expIdx*W +: W] = t.expRes;
      chkVec("R6 buffer", expV);
      @(negedge clk);
      chk(!done && !busy, "R10 done pulse", W'(done), '0);
    end

    // R9 element-wise pass
    run(1'b0, 3'd0, 1'b0, 8'hFF, 4'd8, packB(), cnt);
    chk(cnt == 0 && !errOp && !empty, "R9 pass timing", W'(cnt), '0);
    chk(result == '0, "R9 result", result, '0);
    chkVec("R9 buffer", packB());
    @(negedge clk);

    // R8 single-source codes refused
    for (int c = 6; c < 8; c++) begin
      run(1'b1, 3'(c), 1'b0, 8'hFF, 4'd8, packA(), cnt);
      chk(cnt == 0 && errOp && !empty, "R8 error flag", W'(errOp), 64'd1);
      chk(result == '0, "R8 result", result, '0);
      chkVec("R8 buffer kept", packB());
      @(negedge clk);
    end

    // R11 start during busy ignored
    reduceMode = 1'b1; opSel = 3'd0; isSigned = 1'b0; predMask = 8'hFF; vl = 4'd8; vecIn = packA();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    reduceMode = 1'b0; vecIn = packB(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 2;
    while (!done && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 8, "R11 latency", W'(cnt), 64'd8);
    chk(result == 64'h111, "R11 result", result, 64'h111);
    expV = packA();
    expV[0 +: W] = 64'h111;
    chkVec("R11 buffer", expV);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule